// File: doc/BRIEF.md
# Fetch and Data Space Selector

This block decides, for every memory access a processor core makes, whether the access goes to ROM or to RAM. It holds two flags of the condition register: a fetch-space flag (1 = ROM) and a data-space flag (1 = RAM). Out of reset, code runs from ROM and data lives in RAM. A dedicated command moves instruction fetching to RAM by clearing the fetch flag. Nothing sets the fetch flag directly. The only way back to ROM is a restore of the condition register from saved state, as on a return.

Instruction fetches do not follow the fetch flag itself. They follow a delayed copy of it. That copy loads the flag only on a cycle in which the program counter is written from the ALU output. This lets a control transfer finish in the old space before fetching moves to the new one. Data accesses always use the data-space flag. The selected space is registered and presented one clock after the access is announced.

Top module: `space_selector`

## Requirements
- R1: After synchronous reset, the fetch flag reads 1 (ROM), the data flag reads 1 (RAM), `space_valid` is 0, and the first fetch access selects ROM (`space_ram`=0).
- R2: `set_fetch_ram` without a restore in the same cycle clears the fetch flag at the next edge and leaves the data flag unchanged.
- R3: A change of the fetch flag does not alter the space used by fetch accesses until a program-counter load from the ALU happens. Until then, the flag and the fetch space may disagree.
- R4: On a cycle with `pc_load_alu`=1, the delayed fetch copy takes the fetch flag's next value. Fetch accesses announced in later cycles select RAM exactly when that copy is 0.
- R5: `cc_restore`=1 loads the fetch flag from bit F_BIT and the data flag from bit D_BIT of `cc_restore_word`. The defaults are F_BIT=5 and D_BIT=4. All other bits of the word are ignored.
- R6: When `cc_restore` and `set_fetch_ram` are both asserted in the same cycle, the restored fetch value wins.
- R7: When `cc_restore` and `pc_load_alu` are both asserted in the same cycle, the delayed fetch copy takes the restored fetch value.
- R8: A data access (`acc_is_fetch`=0) selects `space_ram` equal to the data flag as it stood in the announcing cycle, whatever the delayed fetch copy holds.
- R9: `space_valid` is `acc_valid` delayed by one clock. `space_ram` changes only on an edge that follows an announced access, and otherwise holds its value.
- R10: A fetch access announced in the same cycle as `pc_load_alu` still uses the delayed copy as it stood before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_fetch_ram | input | 1 | Command that clears the fetch flag (fetch from RAM) |
| cc_restore | input | 1 | Restore the condition register from the saved word |
| cc_restore_word | input | CC_W | Saved condition register value |
| pc_load_alu | input | 1 | Program counter is written from the ALU this cycle |
| acc_valid | input | 1 | An access is announced this cycle |
| acc_is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| space_valid | output | 1 | Registered access valid |
| space_ram | output | 1 | Registered space select, 1 = RAM, 0 = ROM |
| flag_fetch_rom | output | 1 | Architectural fetch-space flag, 1 = ROM |
| flag_data_ram | output | 1 | Architectural data-space flag, 1 = RAM |

## Verification
The bench builds the block with its default 8-bit condition word, with the fetch flag at bit 5 and the data flag at bit 4. It drives every ordered pair of the 128 seven-bit control vectors. Each vector combines the set command, the restore with both restored flag values, the PC load and the access kind. Running all pairs reaches every combination of flag and delayed copy together with every same-cycle collision of commands. Outside a restore, the unused bits of the restore word are driven opposite to the fetch value, so that any leak from them shows up at the ports.

// File: rtl/ssel_pkg.sv
package ssel_pkg;
  typedef enum logic {
    SPACE_ROM = 1'b0,
    SPACE_RAM = 1'b1
  } space_e;

  function automatic space_e pick_space(input logic is_fetch,
                                        input logic fetch_copy_rom,
                                        input logic data_is_ram);
    if (is_fetch) return fetch_copy_rom ? SPACE_ROM : SPACE_RAM;
    return data_is_ram ? SPACE_RAM : SPACE_ROM;
  endfunction
endpackage

// File: rtl/ssel_cc_flags.sv
module ssel_cc_flags #(
  parameter int CC_W  = 8,
  parameter int F_BIT = 5,
  parameter int D_BIT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_fetch_ram,
  input  logic            cc_restore,
  input  logic [CC_W-1:0] cc_restore_word,
  output logic            fetch_rom,
  output logic            data_ram,
  output logic            fetch_rom_next
);
  logic data_ram_next;

  // restore outranks the set-to-RAM command
  always_comb begin
    fetch_rom_next = fetch_rom;
    data_ram_next  = data_ram;
    if (cc_restore) begin
      fetch_rom_next = cc_restore_word[F_BIT];
      data_ram_next  = cc_restore_word[D_BIT];
    end else if (set_fetch_ram) begin
      fetch_rom_next = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_rom <= 1'b1;
      data_ram  <= 1'b1;
    end else begin
      fetch_rom <= fetch_rom_next;
      data_ram  <= data_ram_next;
    end
  end
endmodule

// File: rtl/ssel_fetch_latch.sv
module ssel_fetch_latch (
  input  logic clk,
  input  logic rst,
  input  logic pc_load_alu,
  input  logic fetch_rom_next,
  output logic copy_rom
);
  always_ff @(posedge clk) begin
    if (rst)              copy_rom <= 1'b1;
    else if (pc_load_alu) copy_rom <= fetch_rom_next;
  end
endmodule

// File: rtl/ssel_access_reg.sv
module ssel_access_reg
  import ssel_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic acc_valid,
  input  logic acc_is_fetch,
  input  logic copy_rom,
  input  logic data_ram,
  output logic space_valid,
  output logic space_ram
);
  space_e sel;

  always_comb sel = pick_space(acc_is_fetch, copy_rom, data_ram);

  always_ff @(posedge clk) begin
    if (rst) begin
      space_valid <= 1'b0;
      space_ram   <= 1'b0;
    end else begin
      space_valid <= acc_valid;
      if (acc_valid) space_ram <= (sel == SPACE_RAM);
    end
  end
endmodule

// File: rtl/space_selector.sv
module space_selector #(
  parameter int CC_W  = 8,
  parameter int F_BIT = 5,
  parameter int D_BIT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_fetch_ram,
  input  logic            cc_restore,
  input  logic [CC_W-1:0] cc_restore_word,
  input  logic            pc_load_alu,
  input  logic            acc_valid,
  input  logic            acc_is_fetch,
  output logic            space_valid,
  output logic            space_ram,
  output logic            flag_fetch_rom,
  output logic            flag_data_ram
);
  logic fetch_next;
  logic copy_rom;

  ssel_cc_flags #(.CC_W(CC_W), .F_BIT(F_BIT), .D_BIT(D_BIT)) u_flags (
    .clk(clk), .rst(rst), .set_fetch_ram(set_fetch_ram),
    .cc_restore(cc_restore), .cc_restore_word(cc_restore_word),
    .fetch_rom(flag_fetch_rom), .data_ram(flag_data_ram),
    .fetch_rom_next(fetch_next)
  );

  ssel_fetch_latch u_latch (
    .clk(clk), .rst(rst), .pc_load_alu(pc_load_alu),
    .fetch_rom_next(fetch_next), .copy_rom(copy_rom)
  );

  ssel_access_reg u_acc (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_is_fetch(acc_is_fetch),
    .copy_rom(copy_rom), .data_ram(flag_data_ram),
    .space_valid(space_valid), .space_ram(space_ram)
  );
endmodule

// File: rtl/space_selector_chk.sv
module space_selector_chk #(
  parameter int CC_W  = 8,
  parameter int F_BIT = 5,
  parameter int D_BIT = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            set_fetch_ram,
  input logic            cc_restore,
  input logic [CC_W-1:0] cc_restore_word,
  input logic            acc_valid,
  input logic            acc_is_fetch,
  input logic            space_valid,
  input logic            space_ram,
  input logic            flag_fetch_rom,
  input logic            flag_data_ram
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q === 1'b1 && !rst)
      assert_reset_flags_R1: assert (flag_fetch_rom && flag_data_ram && !space_valid);
  end

  assert_set_clears_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (set_fetch_ram && !cc_restore) |=> !flag_fetch_rom);

  assert_set_keeps_data_R2: assert property (@(posedge clk) disable iff (rst)
    (set_fetch_ram && !cc_restore) |=> $stable(flag_data_ram));

  assert_restore_loads_R5: assert property (@(posedge clk) disable iff (rst)
    cc_restore |=> (flag_fetch_rom == $past(cc_restore_word[F_BIT]) &&
                    flag_data_ram  == $past(cc_restore_word[D_BIT])));

  assert_valid_delay_R9: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> space_valid);

  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> $stable(space_ram));

  assert_data_uses_dflag_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_is_fetch) |=> (space_ram == $past(flag_data_ram)));
endmodule

bind space_selector space_selector_chk #(.CC_W(CC_W), .F_BIT(F_BIT), .D_BIT(D_BIT)) u_chk (
  .clk(clk), .rst(rst), .set_fetch_ram(set_fetch_ram), .cc_restore(cc_restore),
  .cc_restore_word(cc_restore_word), .acc_valid(acc_valid), .acc_is_fetch(acc_is_fetch),
  .space_valid(space_valid), .space_ram(space_ram),
  .flag_fetch_rom(flag_fetch_rom), .flag_data_ram(flag_data_ram)
);

// File: tb/tb_space_selector.sv
module tb_space_selector;
  localparam int CC_W = 8;
  localparam int F_BIT = 5;
  localparam int D_BIT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic set_fetch_ram = 1'b0, cc_restore = 1'b0, pc_load_alu = 1'b0;
  logic acc_valid = 1'b0, acc_is_fetch = 1'b0;
  logic [CC_W-1:0] cc_restore_word = '0;
  logic space_valid, space_ram, flag_fetch_rom, flag_data_ram;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic mF, mD, mL, mSel;

  always #10 clk = ~clk;

  space_selector #(.CC_W(CC_W), .F_BIT(F_BIT), .D_BIT(D_BIT)) dut (
    .clk(clk), .rst(rst), .set_fetch_ram(set_fetch_ram), .cc_restore(cc_restore),
    .cc_restore_word(cc_restore_word), .pc_load_alu(pc_load_alu),
    .acc_valid(acc_valid), .acc_is_fetch(acc_is_fetch),
    .space_valid(space_valid), .space_ram(space_ram),
    .flag_fetch_rom(flag_fetch_rom), .flag_data_ram(flag_data_ram));

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // one cycle of stimulus; expected values follow the requirements
  task automatic apply(input logic s, input logic r, input logic rf, input logic rd,
                       input logic pc, input logic av, input logic af, input string tag);
    logic fn, dn, ev;
    @(negedge clk);
    set_fetch_ram = s; cc_restore = r; pc_load_alu = pc;
    acc_valid = av; acc_is_fetch = af;
    cc_restore_word = {CC_W{~rf}};      // unused bits opposite to F (R5)
    cc_restore_word[F_BIT] = rf;
    cc_restore_word[D_BIT] = rd;
    ev = av;
    if (av) mSel = af ? ~mL : mD;       // old copy / old data flag (R10, R8)
    fn = r ? rf : (s ? 1'b0 : mF);      // R6
    dn = r ? rd : mD;
    if (pc) mL = fn;                    // R4, R7
    mF = fn; mD = dn;
    @(posedge clk); #5;
    chk(tag, "flag_fetch_rom", flag_fetch_rom, mF);
    chk(tag, "flag_data_ram", flag_data_ram, mD);
    chk("R9", "space_valid", space_valid, ev);
    chk(tag, "space_ram", space_ram, mSel);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mF = 1'b1; mD = 1'b1; mL = 1'b1; mSel = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1", "flag_fetch_rom", flag_fetch_rom, 1'b1);
    chk("R1", "flag_data_ram", flag_data_ram, 1'b1);
    chk("R1", "space_valid", space_valid, 1'b0);
    apply(0,0,0,0,0,1,1,"R1");           // first fetch from ROM
    apply(1,0,0,0,0,1,0,"R2");           // clear fetch flag, data access
    apply(0,0,0,0,0,1,1,"R3");           // fetch still ROM
    apply(0,0,0,0,1,1,1,"R10");          // fetch alongside PC load: old copy
    apply(0,0,0,0,0,1,1,"R4");           // now RAM
    apply(0,1,1,0,0,1,0,"R5");           // restore F=1 D=0
    apply(0,0,0,0,0,1,1,"R3");           // flag ROM, fetch still RAM
    apply(0,0,0,0,0,1,0,"R8");           // data uses D=0
    apply(1,1,1,1,0,0,0,"R6");           // restore beats set
    apply(1,1,0,1,1,0,0,"R7");           // restore with PC load
    apply(0,0,0,0,0,1,1,"R7");
    apply(0,0,0,0,0,0,1,"R9");           // no access: hold
    for (int v = 0; v < 128; v++) begin
      for (int w = 0; w < 128; w++) begin
        apply(v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[6] ? "R4" : "R8");
        apply(w[0], w[1], w[2], w[3], w[4], w[5], w[6], w[1] ? "R5" : "R2");
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule